// File: doc/BRIEF.md
# USB Transaction Status Queue

This block sits between the serial interface engine of a USB device controller and the processor's register bus. Each time the engine finishes with a buffer descriptor, it pushes a status record into the block. The record gives the endpoint number, the transfer direction and which of the two ping-pong buffers was used. Software learns of a finished transaction from a token-done flag. It reads the details through one status register, which is a window onto the oldest queued record.

Up to four records are held, so software can work on one transaction while the engine completes more. Software writes 1 to the token-done bit to retire the record it has handled. The flag drops for one cycle. If another record is waiting, the flag comes back on the next cycle with that record in the window. A push that finds the queue full is discarded and sets a sticky overflow bit.

The register port has two addresses. Address 0 is the interrupt status register. Its bit 0 is token-done and its bit 1 is overflow. Both bits are cleared by writing 1 and the other bits read zero. Address 1 is the read-only status window. Reads are combinational on `reg_addr`.

Top module: `usb_stat_fifo`

## Requirements
- R1: The status window (address 1) reads as {endpoint[3:0], in, odd, 2'b00}: endpoint number in plain binary in bits 7:4, direction (1 = IN) in bit 3, odd-buffer flag in bit 2, bits 1:0 always zero.
- R2: A push into an empty queue with the token-done flag clear sets the flag one cycle later. The flag appears on `tok_done` and in bit 0 of address 0. The pushed record shows in the window in the same cycle.
- R3: While the token-done flag is clear, the status window reads 8'h00.
- R4: Records pushed while the flag is set queue behind the head in arrival order. The head and the flag stay unchanged until software clears the flag.
- R5: Writing a value with bit 0 set to address 0 while the flag is set retires the head, and the flag reads 0 in the next cycle. If a record is still queued, the flag reads 1 one cycle later and the window shows the next record in order.
- R6: Writing to address 0 with bit 0 clear does not change the flag, the window or the queue.
- R7: The queue holds at most 4 records, counting the head. A push that arrives while the queue is full, with no retire in the same cycle, is dropped. The dropped push sets the overflow bit (bit 1 of address 0) and leaves the head and the order of the queued records unchanged.
- R8: The overflow bit stays set until a write to address 0 with bit 1 set. If a dropped push and such a write fall in the same cycle, the bit stays set.
- R9: A push and a retire in the same cycle both take effect. When the queue is full, that push is accepted.
- R10: After synchronous active-low reset, the queue is empty, the flag and the overflow bit are 0, and both addresses read 8'h00.
- R11: Writes to address 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_valid | input | 1 | Engine pushes a status record this cycle |
| push_endp | input | 4 | Endpoint number of the record |
| push_in | input | 1 | Direction of the record, 1 = IN |
| push_odd | input | 1 | Odd-buffer indicator of the record |
| reg_addr | input | 1 | Register address: 0 interrupt status, 1 status window |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| tok_done | output | 1 | Token-done flag, usable as interrupt request |

## Verification
A wrong queue count or pointer shows first at the window. After a retire, the window presents a stale or skipped record one cycle later, when the flag reasserts. A wrong count can also make the flag fail to reassert, or make it reassert on an empty queue. Wrong full detection shows at the next push against a full queue: the overflow bit is set or missed one cycle later, and an overwritten record appears when it reaches the head. A reference queue in the bench is compared with the flag, the interrupt status and the window on every cycle, so any such divergence is reported within a cycle of reaching the ports.

// File: rtl/usb_stat_pkg.sv
// Package: shared status record type and its register encoding.
// Assumes the endpoint field is four bits wide.
package usb_stat_pkg;
    localparam int ENDP_W = 4;

    typedef struct packed {
        logic [ENDP_W-1:0] endp;
        logic              dir_in;
        logic              odd;
    } stat_rec_t;

    localparam int REC_W = $bits(stat_rec_t);

    // Encode a record into the status window byte layout
    function automatic logic [7:0] pack_status(input stat_rec_t r);
        return {r.endp, r.dir_in, r.odd, 2'b00};
    endfunction
endpackage

// File: rtl/stat_queue.sv
// Module: circular queue of status records with head output.
// Assumes push is already qualified (never asserted when full without pop).
module stat_queue
    import usb_stat_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  stat_rec_t        push_rec,
    input  logic             pop,
    output stat_rec_t        head,
    output logic [CNT_W-1:0] count,
    output logic             full
);
    stat_rec_t        slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    // Advance a pointer with wrap at DEPTH
    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // One storage register per slot, loaded on a push aimed at it
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                slots[g] <= '0;
            else if (push && wr_ptr == PTR_W'(g))
                slots[g] <= push_rec;
        end
    end

    // Pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= nxt(wr_ptr);
            if (pop)  rd_ptr <= nxt(rd_ptr);
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    // Head and full indications
    always_comb begin
        head = slots[rd_ptr];
        full = (count == CNT_W'(DEPTH));
    end
endmodule

// File: rtl/tokdone_ctrl.sv
// Module: token-done flag and sticky overflow control.
// Assumes clr_tok and clr_ovf are already decoded write-1 strobes.
module tokdone_ctrl #(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  logic             clr_tok,
    input  logic             clr_ovf,
    input  logic [CNT_W-1:0] count,
    input  logic             full,
    output logic             push_ok,
    output logic             pop,
    output logic             flag,
    output logic             ovf
);
    logic drop;

    // Retire and acceptance decisions for this cycle
    always_comb begin
        pop     = clr_tok && flag;
        push_ok = push_req && (!full || pop);
        drop    = push_req && !push_ok;
    end

    // Flag: held until retired, re-raised when a record is waiting
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (flag)
            flag <= !pop;
        else
            flag <= (count != '0) || push_req;
    end

    // Sticky overflow; a drop wins over a same-cycle clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf <= 1'b0;
        else if (drop)
            ovf <= 1'b1;
        else if (clr_ovf)
            ovf <= 1'b0;
    end
endmodule

// File: rtl/stat_regs.sv
// Module: register read mux and write-1-to-clear decode.
// Assumes address 0 is interrupt status and address 1 the status window.
module stat_regs
    import usb_stat_pkg::*;
(
    input  logic       reg_addr,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    input  logic       flag,
    input  logic       ovf,
    input  stat_rec_t  head,
    output logic [7:0] status_byte,
    output logic [7:0] reg_rdata,
    output logic       clr_tok,
    output logic       clr_ovf
);
    // Window is blank unless the flag marks the head valid
    always_comb begin
        status_byte = flag ? pack_status(head) : 8'h00;
        reg_rdata   = reg_addr ? status_byte : {6'b0, ovf, flag};
    end

    // Write-1-to-clear strobes, only at the interrupt status address
    always_comb begin
        clr_tok = reg_wr && !reg_addr && reg_wdata[0];
        clr_ovf = reg_wr && !reg_addr && reg_wdata[1];
    end
endmodule

// File: rtl/usb_stat_fifo.sv
// Module: top of the transaction status queue.
// Assumes one push per cycle at most and a combinational register read.
module usb_stat_fifo
    import usb_stat_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push_valid,
    input  logic [3:0] push_endp,
    input  logic       push_in,
    input  logic       push_odd,
    input  logic       reg_addr,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       tok_done
);
    stat_rec_t        in_rec, head;
    logic [CNT_W-1:0] count;
    logic             full, push_ok, pop, flag, ovf, clr_tok, clr_ovf;
    logic [7:0]       status_byte;

    // Assemble the incoming record
    always_comb in_rec = '{endp: push_endp, dir_in: push_in, odd: push_odd};

    stat_queue #(.DEPTH(DEPTH)) u_queue (
        .clk(clk), .rst_n(rst_n), .push(push_ok), .push_rec(in_rec),
        .pop(pop), .head(head), .count(count), .full(full)
    );

    tokdone_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .push_req(push_valid), .clr_tok(clr_tok),
        .clr_ovf(clr_ovf), .count(count), .full(full), .push_ok(push_ok),
        .pop(pop), .flag(flag), .ovf(ovf)
    );

    stat_regs u_regs (
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .flag(flag), .ovf(ovf), .head(head), .status_byte(status_byte),
        .reg_rdata(reg_rdata), .clr_tok(clr_tok), .clr_ovf(clr_ovf)
    );

    // Flag doubles as the interrupt request
    always_comb tok_done = flag;
endmodule

// File: rtl/usb_stat_fifo_chk.sv
// Module: property checker for the status queue, bound into the top.
module usb_stat_fifo_chk #(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push_valid,
    input logic             flag,
    input logic             ovf,
    input logic             pop,
    input logic             full,
    input logic [CNT_W-1:0] count,
    input logic [5:0]       head_bits,
    input logic [7:0]       status_byte
);
    // R2: a push with the flag clear raises it next cycle
    a_r2_flag_after_push: assert property (@(posedge clk) disable iff (!rst_n)
        !flag && push_valid |=> flag);

    // R3: window blank while the flag is clear
    a_r3_window_blank: assert property (@(posedge clk) disable iff (!rst_n)
        !flag |-> status_byte == 8'h00);

    // R4: head and flag held until retired
    a_r4_head_held: assert property (@(posedge clk) disable iff (!rst_n)
        flag && !pop |=> flag && $stable(head_bits));

    // R5: flag returns one cycle after a retire that leaves records waiting
    a_r5_reassert: assert property (@(posedge clk) disable iff (!rst_n)
        !flag && count != '0 |=> flag);

    // R7: occupancy never beyond depth
    a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    // R7: a push into a full queue without retire sets overflow
    a_r7_no_overflow_miss: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid && full && !pop |=> ovf);
endmodule

bind usb_stat_fifo usb_stat_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .flag(flag),
    .ovf(ovf), .pop(pop), .full(full), .count(count),
    .head_bits(head), .status_byte(status_byte)
);

// File: tb/test_usb_stat_fifo.sv
// Bench: behavioural reference queue compared with the ports every cycle.
module test_usb_stat_fifo;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       push_valid = 1'b0;
    logic [3:0] push_endp = '0;
    logic       push_in = 1'b0, push_odd = 1'b0;
    logic       reg_addr = 1'b0, reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       tok_done;

    int checks = 0, failures = 0;
    logic [7:0] mq[$];
    logic m_flag = 1'b0, m_ovf = 1'b0;

    always #10 clk = ~clk;

    usb_stat_fifo i_usb_stat_fifo (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_endp(push_endp),
        .push_in(push_in), .push_odd(push_odd), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tok_done(tok_done)
    );

    task automatic check(input string tag, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
        end
    endtask

    // Advance one clock: update the model from the applied inputs, then compare
    task automatic step(input string tag);
        logic pop, acc;
        @(posedge clk);
        if (!rst_n) begin
            mq.delete(); m_flag = 1'b0; m_ovf = 1'b0;
        end else begin
            pop = reg_wr && !reg_addr && reg_wdata[0] && m_flag;
            acc = push_valid && ((mq.size() - int'(pop)) < 4);
            if (pop) void'(mq.pop_front());
            if (acc) mq.push_back({push_endp, push_in, push_odd, 2'b00});
            if (push_valid && !acc) m_ovf = 1'b1;
            else if (reg_wr && !reg_addr && reg_wdata[1]) m_ovf = 1'b0;
            if (m_flag) m_flag = !pop;
            else m_flag = (mq.size() != 0);
        end
        @(negedge clk);
        reg_wr = 1'b0; push_valid = 1'b0;
        reg_addr = 1'b1; #1;
        check(tag, "window", reg_rdata, m_flag ? mq[0] : 8'h00);
        reg_addr = 1'b0; #1;
        check(tag, "intstat", reg_rdata, {6'b0, m_ovf, m_flag});
        check(tag, "tok_done", {7'b0, tok_done}, {7'b0, m_flag});
    endtask

    task automatic push(input logic [3:0] e, input logic i, input logic o);
        push_valid = 1'b1; push_endp = e; push_in = i; push_odd = o;
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    endtask

    initial begin
        #4_000_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        step("R10"); step("R10");
        rst_n = 1'b1;
        step("R10");
        push(4'h5, 1'b1, 1'b0); step("R2");            // window 58
        step("R1");
        wr(1'b0, 8'h00); step("R6");                     // no-op write
        wr(1'b1, 8'hFF); step("R11");                    // window is read-only
        push(4'hA, 1'b0, 1'b1); step("R4");
        push(4'h3, 1'b1, 1'b1); step("R4");
        push(4'hF, 1'b0, 1'b0); step("R4");              // queue now full
        push(4'h7, 1'b1, 1'b1); step("R7");              // dropped, overflow set
        step("R8");
        push(4'h2, 1'b0, 1'b0); wr(1'b0, 8'h02); step("R8"); // drop beats clear
        wr(1'b0, 8'h02); step("R8");                     // overflow cleared
        push(4'h9, 1'b1, 1'b0); wr(1'b0, 8'h01); step("R9"); // full, push + retire
        step("R5");                                      // flag back, next record
        wr(1'b0, 8'h01); step("R5");
        step("R5");
        wr(1'b0, 8'h01); push(4'h1, 1'b0, 1'b1); step("R9");
        step("R9");
        for (int k = 0; k < 6; k++) begin
            wr(1'b0, 8'h01); step("R5");
            step("R5");
        end
        step("R3");
        wr(1'b0, 8'h01); step("R3");                     // clear with flag low
        for (int k = 0; k < 400; k++) begin
            if ($urandom_range(0, 2) == 0)
                push(4'($urandom), 1'($urandom), 1'($urandom));
            if ($urandom_range(0, 2) == 0)
                wr(1'($urandom_range(0, 3) == 0), 8'($urandom));
            step("R9");
        end
        rst_n = 1'b0; step("R10");
        rst_n = 1'b1; step("R10");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule